// File: doc/BRIEF.md
# System Address Interleave Decoder

This block maps a physical address to the socket, memory controller and channel that own it. For each socket it holds a table of range rules. Each rule has an interleave-target word paired with it. It also holds a packed route word and a socket identifier per socket. Software loads all of these through a single-cycle write port.

A lookup starts when a request arrives while the block is idle. Addresses in the low I/O hole, and addresses at or above the top of memory, are refused at once. Otherwise the block walks socket 0's rules, one rule per clock, until a rule matches. It then extracts an interleave index from the address and uses it to pick a 4-bit target. If the target points at another socket, the walk restarts once on that socket's table. A local target gives a logical channel, either directly or through modulo-3 / modulo-2 arithmetic on a shifted address. The logical channel indexes the route word to give the controller and channel. Every lookup ends with a one-cycle `done` pulse carrying either `ok` or `err`.

Top module: `sys_addr_interleave_dec`

## Requirements
- R1: A request whose address is at or above `tohm`, or at or above `tolm` and below 2^32, completes with `done` and `err` on the accepting clock edge itself, with no rule walk.
- R2: Rule word bit 0 enables the rule. Its upper bound is bits [26:7] placed at address bit 26, with address bits [25:0] all ones. Its lower bound is the previous rule's bound plus one, or zero for rule 0. The lower bound advances past disabled rules too. The first enabled rule whose range holds the address is the match.
- R3: If no rule in the table matches, the lookup ends in `err` after all NUM_RULES rules have been visited.
- R4: Rule bits [2:1] select the 3-bit interleave index: 0 picks address [8:6], 1 picks [10:8], 2 picks [14:12], 3 picks [32:30]. The target is the nibble at bits [4*index+3 : 4*index] of the paired interleave word.
- R5: A target with bit 3 clear is remote. Its bits [2:0] name a socket identifier, and the walk restarts at rule 0 of the socket holding that identifier. The reported socket is the identifier of the socket where the lookup finishes.
- R6: A second remote target within one lookup ends in `err`. A remote target whose identifier no socket holds also ends in `err`.
- R7: With rule bit 27 clear, the logical channel is target bits [2:0].
- R8: With rule bit 27 set, rule bits [31:30] give the shift: 0 gives 6, 1 gives 8, 2 gives 12. The value 3 ends the lookup in `err`.
- R9: Under bit 27, let s be the address shifted right by that shift. Rule bits [6:5] produce v as follows: 0 gives s mod 3; 1 gives s mod 2; 2 gives {b, not b} with b = s mod 2; 3 gives {s mod 2, 0}. The logical channel is {v, target bit 0}.
- R10: For logical channel l, the controller is route bits [3l+2:3l] and the channel is route bits [2l+19:2l+18].
- R11: A local match at rule k of the first table raises `done` k+1 clocks after the accepting edge. Each redirect adds the visited rules of the next table. `busy` is high while walking. Requests seen while busy are ignored. Exactly one of `ok` and `err` is high with `done`.
- R12: On a `cfg_we` cycle, `cfg_sel` selects the target of the write. 0 writes the rule word at (`cfg_skt`, `cfg_idx`). 1 writes the interleave word at the same place. 2 writes the route word of `cfg_skt`. 3 writes the socket identifier of `cfg_skt` from `cfg_data[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target select (R12) |
| cfg_skt | input | SKT_W | Socket table written |
| cfg_idx | input | RULE_W | Rule entry written |
| cfg_data | input | 32 | Write data |
| tolm | input | 46 | Top of low memory |
| tohm | input | 46 | Top of high memory |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 46 | Physical address to decode |
| busy | output | 1 | Rule walk in progress |
| done | output | 1 | One-cycle result pulse |
| ok | output | 1 | Lookup succeeded (with done) |
| err | output | 1 | Lookup failed (with done) |
| rsp_socket | output | 3 | Identifier of the owning socket |
| rsp_mc | output | 3 | Memory controller |
| rsp_chan | output | 2 | Channel |

## Verification
The bench builds the block with its defaults: 24 rules and two sockets. Two sockets are the minimum that makes a remote redirect possible. They also allow a second remote hop back to the first socket and a target naming an identifier held by neither. The full 24-entry table lets the bench time the worst case: a miss that walks every rule, with the scan counter reaching its last index. Socket 0 holds nine hand-built rules, which together cover every interleave selector, every modulo mode, the illegal shift mode and a disabled rule between two enabled ones.

// File: rtl/sys_addr_interleave_dec.sv
module sys_addr_interleave_dec #(
  parameter int NUM_RULES = 24,
  parameter int NUM_SKT   = 2,
  localparam int RULE_W   = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1,
  localparam int SKT_W    = (NUM_SKT > 1) ? $clog2(NUM_SKT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [SKT_W-1:0]  cfg_skt,
  input  logic [RULE_W-1:0] cfg_idx,
  input  logic [31:0]       cfg_data,
  input  logic [45:0]       tolm,
  input  logic [45:0]       tohm,
  input  logic              req_valid,
  input  logic [45:0]       req_addr,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              err,
  output logic [2:0]        rsp_socket,
  output logic [2:0]        rsp_mc,
  output logic [1:0]        rsp_chan
);

  logic [31:0] rule_q [NUM_SKT][NUM_RULES];
  logic [31:0] ilv_q  [NUM_SKT][NUM_RULES];
  logic [31:0] route_q [NUM_SKT];
  logic [2:0]  sid_q   [NUM_SKT];

  always_ff @(posedge clk)
    if (cfg_we)
      case (cfg_sel)
        2'd0: rule_q[cfg_skt][cfg_idx] <= cfg_data;
        2'd1: ilv_q[cfg_skt][cfg_idx]  <= cfg_data;
        2'd2: route_q[cfg_skt]         <= cfg_data;
        default: sid_q[cfg_skt]        <= cfg_data[2:0];
      endcase

  logic              busy_q, redir_q;
  logic [SKT_W-1:0]  cur;
  logic [RULE_W-1:0] ri;
  logic [45:0]       lo_q, addr_q;

  function automatic logic [1:0] mod3(input logic [45:0] x);
    logic [2:0] r;
    r = '0;
    for (int i = 0; i < 23; i++) begin
      r = r + {1'b0, x[2*i +: 2]};
      if (r >= 3'd3) r = r - 3'd3;
    end
    return r[1:0];
  endfunction

  wire [31:0] rule  = rule_q[cur][ri];
  wire [31:0] ilv   = ilv_q[cur][ri];
  wire [31:0] route = route_q[cur];
  wire [45:0] limit = {rule[26:7], 26'h3FF_FFFF};
  wire        hit   = rule[0] && addr_q >= lo_q && addr_q <= limit;
  wire        oor   = req_addr >= tohm || (req_addr >= tolm && req_addr < 46'h1_0000_0000);
  logic unused_bits;
  assign unused_bits = ^rule[4:3];

  logic [2:0] idx;
  always_comb
    case (rule[2:1])
      2'd0: idx = addr_q[8:6];
      2'd1: idx = addr_q[10:8];
      2'd2: idx = addr_q[14:12];
      default: idx = addr_q[32:30];
    endcase

  wire [3:0] tgt    = 4'(ilv >> {idx, 2'b00});
  wire       remote = !tgt[3];

  logic             found;
  logic [SKT_W-1:0] fskt;
  always_comb begin
    found = 1'b0;
    fskt  = '0;
    for (int k = 0; k < NUM_SKT; k++)
      if (!found && sid_q[k] == tgt[2:0]) begin
        found = 1'b1;
        fskt  = SKT_W'(k);
      end
  end

  logic [3:0] shamt;
  always_comb
    case (rule[31:30])
      2'd0: shamt = 4'd6;
      2'd1: shamt = 4'd8;
      default: shamt = 4'd12;
    endcase
  wire        illegal = rule[27] && rule[31:30] == 2'd3;
  wire [45:0] s       = addr_q >> shamt;

  logic [1:0] v;
  always_comb
    case (rule[6:5])
      2'd0: v = mod3(s);
      2'd1: v = {1'b0, s[0]};
      2'd2: v = {s[0], !s[0]};
      default: v = {s[0], 1'b0};
    endcase

  wire [2:0] lch    = rule[27] ? {v, tgt[0]} : tgt[2:0];
  wire [2:0] mc_n   = 3'(route >> (6'(lch) * 6'd3));
  wire [1:0] chan_n = 2'(route >> (6'd18 + 6'(lch) * 6'd2));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0; redir_q <= 1'b0; cur <= '0; ri <= '0;
      lo_q <= '0; addr_q <= '0;
      done <= 1'b0; ok <= 1'b0; err <= 1'b0;
      rsp_socket <= '0; rsp_mc <= '0; rsp_chan <= '0;
    end else begin
      done <= 1'b0; ok <= 1'b0; err <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          addr_q <= req_addr;
          if (oor) begin
            done <= 1'b1; err <= 1'b1;
          end else begin
            busy_q <= 1'b1; cur <= '0; ri <= '0; lo_q <= '0; redir_q <= 1'b0;
          end
        end
      end else if (hit) begin
        if (remote && !redir_q && found) begin
          cur <= fskt; ri <= '0; lo_q <= '0; redir_q <= 1'b1;
        end else begin
          busy_q <= 1'b0; done <= 1'b1;
          if (remote || illegal) err <= 1'b1;
          else begin
            ok <= 1'b1; rsp_socket <= sid_q[cur]; rsp_mc <= mc_n; rsp_chan <= chan_n;
          end
        end
      end else if (ri == RULE_W'(NUM_RULES - 1)) begin
        busy_q <= 1'b0; done <= 1'b1; err <= 1'b1;
      end else begin
        ri <= ri + 1'b1; lo_q <= limit + 46'd1;
      end
    end

  assign busy = busy_q;

  AST_REJECT_AT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && req_valid && oor |=> done && err && !busy_q); // R1
  AST_RESULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({ok, err})); // R11
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable(addr_q)); // R11
  AST_REDIRECT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && hit && remote && !redir_q && found |=> busy_q && ri == '0 && redir_q); // R5
  AST_SECOND_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && hit && remote && redir_q |=> done && err); // R6
  AST_ILLEGAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && hit && !remote && illegal |=> done && err); // R8
  AST_MISS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !hit && ri == RULE_W'(NUM_RULES - 1) |=> done && err); // R3

endmodule

// File: tb/sys_addr_interleave_dec_tb.sv
module sys_addr_interleave_dec_tb;
  localparam int NR = 24;
  localparam int NS = 2;
  localparam int RW = $clog2(NR);
  localparam int SW = $clog2(NS);

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [SW-1:0] cfg_skt = 0;
  logic [RW-1:0] cfg_idx = 0;
  logic [31:0] cfg_data = 0;
  logic [45:0] tolm = 46'h8000_0000, tohm = 46'h100_0000_0000;
  logic req_valid = 0;
  logic [45:0] req_addr = 0;
  logic busy, done, ok, err;
  logic [2:0] rsp_socket, rsp_mc;
  logic [1:0] rsp_chan;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sys_addr_interleave_dec #(.NUM_RULES(NR), .NUM_SKT(NS)) u_dut (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_skt, .cfg_idx, .cfg_data, .tolm, .tohm,
    .req_valid, .req_addr, .busy, .done, .ok, .err, .rsp_socket, .rsp_mc, .rsp_chan);

  // {err, socket, mc, chan, addr}
  localparam int NV = 24;
  localparam logic [54:0] VEC [NV] = '{
    {1'b0, 3'd2, 3'd1, 2'd1, 46'h40},          // R4 sel0, R7
    {1'b0, 3'd2, 3'd5, 2'd1, 46'h140},         // R7 R10
    {1'b0, 3'd2, 3'd1, 2'd1, 46'h1C0},         // R4 index 7
    {1'b1, 3'd0, 3'd0, 2'd0, 46'h400_0040},    // R2 disabled rule
    {1'b0, 3'd2, 3'd2, 2'd2, 46'h800_0200},    // R4 sel1
    {1'b1, 3'd0, 3'd0, 2'd0, 46'h800_0000},    // R6 unknown id
    {1'b1, 3'd0, 3'd0, 2'd0, 46'h800_0100},    // R6 double remote
    {1'b0, 3'd5, 3'd1, 2'd3, 46'h800_0300},    // R5 redirect
    {1'b0, 3'd2, 3'd3, 2'd3, 46'h1000_0000},   // R9 mod3 = 1
    {1'b0, 3'd2, 3'd5, 2'd1, 46'h1000_0040},   // R9 mod3 = 2
    {1'b0, 3'd2, 3'd1, 2'd1, 46'h1000_0080},   // R9 mod3 = 0
    {1'b0, 3'd2, 3'd3, 2'd3, 46'h1FFF_FFC0},   // R9 long digit sum
    {1'b0, 3'd2, 3'd2, 2'd2, 46'h2000_0100},   // R8 shift 8, R9 mod2
    {1'b0, 3'd2, 3'd0, 2'd0, 46'h2000_0000},   // R9 mod2 even
    {1'b0, 3'd2, 3'd3, 2'd3, 46'h4000_0000},   // R8 shift 12, R9 mode2 b=0
    {1'b0, 3'd2, 3'd5, 2'd1, 46'h4000_1000},   // R9 mode2 b=1
    {1'b0, 3'd2, 3'd4, 2'd0, 46'h6000_0040},   // R9 mode3
    {1'b1, 3'd0, 3'd0, 2'd0, 46'h7000_0000},   // R8 illegal mode
    {1'b0, 3'd2, 3'd4, 2'd0, 46'h1_0000_0000}, // R4 sel3
    {1'b0, 3'd2, 3'd5, 2'd1, 46'h1_4000_0000}, // R4 sel3
    {1'b1, 3'd0, 3'd0, 2'd0, 46'h2_0000_0000}, // R3 no match
    {1'b1, 3'd0, 3'd0, 2'd0, 46'h8000_0000},   // R1 hole start
    {1'b1, 3'd0, 3'd0, 2'd0, 46'hFFFF_FFFF},   // R1 hole end
    {1'b1, 3'd0, 3'd0, 2'd0, 46'h100_0000_0000} // R1 top of memory
  };

  task automatic chk(input logic c, input string req, input longint act, input longint exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int skt, input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_skt = SW'(skt); cfg_idx = RW'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(input logic [45:0] a, output int lat);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(posedge clk); #1;
    req_valid = 0; lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk); #1;
      lat++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(posedge clk);
    #1;
    chk(!done && !busy && !ok && !err, "R11 reset state", {busy, done, ok, err}, 0);
    rst_n = 1;
    for (int s = 0; s < NS; s++)
      for (int r = 0; r < NR; r++) begin
        wr(2'd0, s, r, 32'h0);
        wr(2'd1, s, r, 32'h0);
      end
    // R12 configuration
    wr(2'd3, 0, 0, 32'd2);
    wr(2'd3, 1, 0, 32'd5);
    wr(2'd2, 0, 0, 32'h1392_C688);
    wr(2'd2, 1, 0, 32'h2C6C_14E5);
    wr(2'd0, 0, 0, 32'h0000_0001); wr(2'd1, 0, 0, 32'h98DC_BA98);
    wr(2'd0, 0, 1, 32'h0000_0080);
    wr(2'd0, 0, 2, 32'h0000_0183); wr(2'd1, 0, 2, 32'hBBBB_5A53);
    wr(2'd0, 0, 3, 32'h0800_0385); wr(2'd1, 0, 3, 32'h9999_9999);
    wr(2'd0, 0, 4, 32'h4800_07A1); wr(2'd1, 0, 4, 32'h8888_8888);
    wr(2'd0, 0, 5, 32'h8800_0BC1); wr(2'd1, 0, 5, 32'h9999_9999);
    wr(2'd0, 0, 6, 32'h0800_0DE1); wr(2'd1, 0, 6, 32'h8888_8888);
    wr(2'd0, 0, 7, 32'hC800_0F81); wr(2'd1, 0, 7, 32'h8888_8888);
    wr(2'd0, 0, 8, 32'h0000_3F87); wr(2'd1, 0, 8, 32'hCCDC_CCCC);
    wr(2'd0, 1, 0, 32'h0000_0183); wr(2'd1, 1, 0, 32'hCCCC_CC2C);

    for (int i = 0; i < NV; i++) begin
      logic [54:0] e;
      e = VEC[i];
      run(e[45:0], lat);
      chk(done && err == e[54] && ok == !e[54], "R2/R4-R10 status", {done, ok, err}, {1'b1, !e[54], e[54]});
      if (!e[54])
        chk({rsp_socket, rsp_mc, rsp_chan} == e[53:46], "R5/R10 result",
            {rsp_socket, rsp_mc, rsp_chan}, e[53:46]);
    end

    run(46'h40, lat);
    chk(lat == 1, "R11 latency rule 0", lat, 1);
    run(46'h800_0200, lat);
    chk(lat == 3, "R11 latency rule 2", lat, 3);
    run(46'h800_0300, lat);
    chk(lat == 4, "R5 latency after redirect", lat, 4);
    run(46'h8000_0000, lat);
    chk(lat == 0 && err, "R1 reject on accept edge", lat, 0);
    run(46'h2_0000_0000, lat);
    chk(lat == NR && err, "R3 full table walk", lat, NR);

    // R11: requests during a walk are ignored
    @(negedge clk);
    req_valid = 1; req_addr = 46'h2_0000_0000;
    @(posedge clk); #1;
    chk(busy, "R11 busy after accept", busy, 1);
    lat = 0;
    req_addr = 46'h40;
    while (!done && lat < 100) begin
      @(posedge clk); #1;
      lat++;
      if (lat == 4) req_valid = 0;
    end
    chk(lat == NR && err && !ok, "R11 ignored request", lat, NR);
    @(posedge clk); #1;
    chk(!busy && !done, "R11 idle after ignored request", {busy, done}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule